// File: doc/BRIEF.md
# Prescaled Interrupt Counter with Scrambled Loads

This block is a programmable event counter that raises an interrupt request. A CPU writes eight byte-wide registers through a 4 KiB address window. The low three address bits pick the register, so the eight registers repeat across the whole window. The counting chain has two stages:

- A prescaler, 8 bits wide by default and 12 bits when widened.
- An 8-bit main counter, which steps once for each prescaler wrap and whose value is always visible on an output.

Outside logic supplies up to four count-event pulse sources, for example bus-cycle ticks or line detection. A mode register picks one of the sources and sets the counting direction. The direction can be upward, downward or halted.

Loads into the prescaler and into the main counter are not taken literally. Each written byte is first XORed with a key byte, which is written through its own register. When the main counter wraps while interrupts are enabled, the request line goes high. It stays high until software writes the disable register.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, `irq` is 0 and `count_val` is 0x00. The mode is halted, interrupts are disabled, and the key and prescaler are 0.
- R2: A write to register 5 sets the main counter to the written byte XOR the key. The key is held in register 6.
- R3: A write to register 4 sets the low 8 prescaler bits to the written byte XOR the key, and clears the upper prescaler bits.
- R4: With mode bits [7:6] = 01, each selected event increments the prescaler. Each prescaler wrap (all ones to zero) increments the main counter by one, so from a zero prescaler the 256th event steps the counter.
- R5: With mode bits [7:6] = 10, each selected event decrements the prescaler. Each prescaler wrap (zero to all ones) decrements the main counter by one.
- R6: With mode bits [7:6] = 00 or 11, events are ignored and the main counter keeps its value.
- R7: Mode bits [1:0] select which bit of `evt_in` is counted. Pulses on the other three bits have no effect.
- R8: When mode bit 3 is set and register 7 holds 0xFF, the prescaler is 12 bits wide. From zero, the 4096th event steps the main counter and the 4095th does not.
- R9: When mode bit 3 is clear, register 7 has no effect and the prescaler stays 8 bits wide, even with 0xFF written there.
- R10: When interrupts are enabled and the main counter wraps (0xFF to 0x00 upward, 0x00 to 0xFF downward), `irq` rises one cycle after the stepping event. It then stays high through further events and writes to other registers.
- R11: A wrap while interrupts are disabled leaves `irq` low. A write to register 3 enables interrupts.
- R12: A write to register 0 disables interrupts and drops `irq` in the next cycle.
- R13: Writes whose address lies outside the window `0xC000–0xCFFF` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address; bits [2:0] pick the register |
| wr_data | input | 8 | CPU write data |
| evt_in | input | 4 | Count-event pulses, one per source |
| irq | output | 1 | Interrupt request, held until cleared |
| count_val | output | 8 | Current main counter value |

## Verification
The assertions take each count event to be a single-cycle pulse that the bench places away from register writes. This matters because a load in the same cycle as a step lets the load win, and the step properties exclude that case. The interrupt properties assume that the disable and enable writes are the only paths that touch the enable state. They also assume a wrap is the only way the request can rise.

The stimulus writes one register at a time. Event pulses are separated by idle cycles, and events start only after the prescaler and counter loads have settled. Every check is therefore taken while the strobe is low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int CW    = 8;
    localparam int SRC_N = 4;
    localparam int SRC_W = $clog2(SRC_N);

    typedef enum logic [1:0] {
        DIR_HALT_A = 2'b00,
        DIR_UP     = 2'b01,
        DIR_DOWN   = 2'b10,
        DIR_HALT_B = 2'b11
    } dir_e;

    typedef enum logic [2:0] {
        REG_IRQ_OFF = 3'd0,
        REG_MODE    = 3'd1,
        REG_SPARE   = 3'd2,
        REG_IRQ_ON  = 3'd3,
        REG_PRE_LD  = 3'd4,
        REG_CNT_LD  = 3'd5,
        REG_KEY     = 3'd6,
        REG_SIZE    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        dir_e             dir;
        logic             size_en;
        logic [SRC_W-1:0] src;
    } mode_t;

    typedef struct packed {
        mode_t         mode;
        logic [CW-1:0] key;
        logic [CW-1:0] size;
        logic          irq_en;
    } cfg_t;

    typedef struct packed {
        logic          pre_ld;
        logic          cnt_ld;
        logic          irq_off;
        logic [CW-1:0] val;
    } load_t;

    function automatic logic dir_active(input dir_e d);
        return (d == DIR_UP) || (d == DIR_DOWN);
    endfunction

    function automatic mode_t decode_mode(input logic [CW-1:0] b);
        mode_t m;
        m.dir     = dir_e'(b[7:6]);
        m.size_en = b[3];
        m.src     = b[SRC_W-1:0];
        return m;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000,
    parameter logic [ADDR_W-1:0] WIN_MASK = 16'hF000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output cfg_t              cfg,
    output load_t             ld
);

    logic     hit;
    reg_sel_e sel;

    assign hit = wr_en && ((wr_addr & WIN_MASK) == WIN_BASE);
    assign sel = reg_sel_e'(wr_addr[2:0]);

    always_comb begin
        ld.pre_ld  = hit && (sel == REG_PRE_LD);
        ld.cnt_ld  = hit && (sel == REG_CNT_LD);
        ld.irq_off = hit && (sel == REG_IRQ_OFF);
        ld.val     = wr_data ^ cfg.key;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (hit) begin
            case (sel)
                REG_IRQ_OFF: cfg.irq_en <= 1'b0;
                REG_IRQ_ON:  cfg.irq_en <= 1'b1;
                REG_MODE:    cfg.mode   <= decode_mode(wr_data);
                REG_KEY:     cfg.key    <= wr_data;
                REG_SIZE:    cfg.size   <= wr_data;
                default:     ;
            endcase
        end
    end

    AST_KEY_HELD: assert property (@(posedge clk) disable iff (rst)
        !(hit && sel == REG_KEY) |=> $stable(cfg.key)); // R2

    AST_OUTSIDE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cfg)); // R13

endmodule

// File: rtl/irqc_prescaler.sv
module irqc_prescaler
    import irqc_pkg::*;
#(
    parameter int EXT_W = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  dir_e          dir,
    input  logic          wide,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic          carry
);

    localparam int HI_W = EXT_W - CW;

    logic [EXT_W-1:0] pre;
    logic             step;
    logic             up;
    logic [CW-1:0]    lo_next;
    logic             narrow_edge;
    logic             wide_edge;

    assign step = tick && dir_active(dir) && !ld;
    assign up   = (dir == DIR_UP);

    assign lo_next     = up ? pre[CW-1:0] + 1'b1 : pre[CW-1:0] - 1'b1;
    assign narrow_edge = up ? (pre[CW-1:0] == '1) : (pre[CW-1:0] == '0);
    assign wide_edge   = up ? (pre == '1) : (pre == '0);

    assign carry = step && (wide ? wide_edge : narrow_edge);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
        end else if (ld) begin
            pre <= {{HI_W{1'b0}}, ld_val};
        end else if (step) begin
            if (wide) pre <= up ? pre + 1'b1 : pre - 1'b1;
            else      pre <= {{HI_W{1'b0}}, lo_next};
        end
    end

    AST_LOAD_CLEARS_HIGH: assert property (@(posedge clk) disable iff (rst)
        ld |=> (pre[EXT_W-1:CW] == '0)); // R3

    AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (step && !wide) |=> (pre[EXT_W-1:CW] == '0)); // R9

    AST_IDLE_PRE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld) |=> $stable(pre)); // R6

endmodule

// File: rtl/irqc_counter.sv
module irqc_counter
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  dir_e          dir,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    logic up;
    logic adv;

    assign up   = (dir == DIR_UP);
    assign adv  = step && dir_active(dir) && !ld;
    assign wrap = adv && (up ? (cnt == '1) : (cnt == '0));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (ld)   cnt <= ld_val;
        else if (adv)  cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt == $past(ld_val))); // R2

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !ld && dir == DIR_UP) |=> (cnt == CW'($past(cnt) + 1'b1))); // R4

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !ld && dir == DIR_DOWN) |=> (cnt == CW'($past(cnt) - 1'b1))); // R5

    AST_HALT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ld && !dir_active(dir)) |=> $stable(cnt)); // R6

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000,
    parameter logic [ADDR_W-1:0] WIN_MASK = 16'hF000,
    parameter int                EXT_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [SRC_N-1:0]  evt_in,
    output logic              irq,
    output logic [CW-1:0]     count_val
);

    cfg_t  cfg;
    load_t ld;
    logic  tick;
    logic  wide;
    logic  carry;
    logic  wrap;

    irqc_regs #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .WIN_MASK(WIN_MASK)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cfg    (cfg),
        .ld     (ld)
    );

    assign tick = evt_in[cfg.mode.src];
    assign wide = cfg.mode.size_en && (cfg.size == '1);

    irqc_prescaler #(.EXT_W(EXT_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .dir   (cfg.mode.dir),
        .wide  (wide),
        .ld    (ld.pre_ld),
        .ld_val(ld.val),
        .carry (carry)
    );

    irqc_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .step  (carry),
        .dir   (cfg.mode.dir),
        .ld    (ld.cnt_ld),
        .ld_val(ld.val),
        .cnt   (count_val),
        .wrap  (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst)                      irq <= 1'b0;
        else if (ld.irq_off)          irq <= 1'b0;
        else if (wrap && cfg.irq_en)  irq <= 1'b1;
    end

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq && !ld.irq_off) |=> irq); // R10

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        ld.irq_off |=> !irq); // R12

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(cfg.irq_en)); // R11

    AST_CARRY_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        carry |-> $past(count_val) == $past(count_val) && tick); // R7

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  evt_in = '0;
    logic        irq;
    logic [7:0]  count_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irqc_top dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .evt_in   (evt_in),
        .irq      (irq),
        .count_val(count_val)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr_raw(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input int ofs, input logic [7:0] d);
        wr_raw(16'hC000 | 16'(ofs), d);
    endtask

    task automatic pulse(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            evt_in[idx] = 1'b1;
            @(negedge clk);
            evt_in = '0;
        end
    endtask

    task automatic t_reset;
        check("R1 irq", irq, 0);
        check("R1 count", count_val, 8'h00);
        pulse(0, 300);
        check("R1 halted after reset", count_val, 8'h00);
    endtask

    task automatic t_loads;
        wr(6, 8'h0F);
        wr(5, 8'hA5);
        check("R2 count load xor key", count_val, 8'hAA);
        wr(1, 8'h40);
        wr(4, 8'hF0);          // prescaler = 0xFF
        wr(5, 8'h1F);          // counter = 0x10
        pulse(0, 1);
        check("R3 prescaler load xor key", count_val, 8'h11);
    endtask

    task automatic t_up;
        wr(6, 8'h00);
        wr(1, 8'h40);
        wr(4, 8'h00);
        wr(5, 8'h20);
        pulse(0, 255);
        check("R4 before wrap", count_val, 8'h20);
        pulse(0, 1);
        check("R4 step up", count_val, 8'h21);
    endtask

    task automatic t_down;
        wr(6, 8'h00);
        wr(1, 8'h80);
        wr(4, 8'h02);
        wr(5, 8'h05);
        pulse(0, 2);
        check("R5 before wrap", count_val, 8'h05);
        pulse(0, 1);
        check("R5 step down", count_val, 8'h04);
    endtask

    task automatic t_halt;
        wr(6, 8'h00);
        wr(4, 8'hFF);
        wr(5, 8'h33);
        wr(1, 8'h00);
        pulse(0, 300);
        check("R6 mode 00 halted", count_val, 8'h33);
        wr(1, 8'hC0);
        pulse(0, 300);
        check("R6 mode 11 halted", count_val, 8'h33);
    endtask

    task automatic t_source;
        wr(6, 8'h00);
        wr(1, 8'h42);
        wr(4, 8'hFF);
        wr(5, 8'h50);
        pulse(0, 1); pulse(1, 1); pulse(3, 1);
        check("R7 other sources ignored", count_val, 8'h50);
        pulse(2, 1);
        check("R7 selected source", count_val, 8'h51);
    endtask

    task automatic t_wide;
        wr(6, 8'h00);
        wr(7, 8'hFF);
        wr(1, 8'h48);
        wr(4, 8'h00);
        wr(5, 8'h00);
        pulse(0, 4095);
        check("R8 no step at 4095", count_val, 8'h00);
        pulse(0, 1);
        check("R8 step at 4096", count_val, 8'h01);
    endtask

    task automatic t_size_ignored;
        wr(6, 8'h00);
        wr(7, 8'hFF);
        wr(1, 8'h40);
        wr(4, 8'h00);
        wr(5, 8'h00);
        pulse(0, 256);
        check("R9 size ignored, 8-bit", count_val, 8'h01);
    endtask

    task automatic t_irq;
        wr(6, 8'h00);
        wr(0, 8'h00);
        wr(1, 8'h40);
        wr(4, 8'hFF);
        wr(5, 8'hFF);
        pulse(0, 1);
        check("R11 wrap disabled count", count_val, 8'h00);
        check("R11 no irq when disabled", irq, 0);
        wr(3, 8'h00);
        wr(4, 8'hFF);
        wr(5, 8'hFF);
        pulse(0, 1);
        check("R10 wrap count", count_val, 8'h00);
        check("R10 irq up wrap", irq, 1);
        pulse(0, 20);
        wr(5, 8'h12);
        wr(6, 8'h34);
        check("R10 irq held", irq, 1);
        wr(0, 8'h00);
        check("R12 irq cleared", irq, 0);
        wr(6, 8'h00);
        wr(3, 8'h00);
        wr(1, 8'h80);
        wr(4, 8'h00);
        wr(5, 8'h00);
        pulse(0, 1);
        check("R5 down wrap count", count_val, 8'hFF);
        check("R10 irq down wrap", irq, 1);
        wr(0, 8'h00);
        check("R12 irq cleared again", irq, 0);
    endtask

    task automatic t_window;
        wr(6, 8'h00);
        wr(5, 8'h44);
        wr_raw(16'hD005, 8'h99);
        wr_raw(16'hB005, 8'h99);
        check("R13 outside window", count_val, 8'h44);
        wr_raw(16'hCFF5, 8'h66);
        check("R13 mirrored inside window", count_val, 8'h66);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_loads;
        t_up;
        t_down;
        t_halt;
        t_source;
        t_wide;
        t_size_ignored;
        t_irq;
        t_window;
        done = 1'b1;
        summary;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary;
        end
    end

endmodule